// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a bitstream into a programmable target device over its serial configuration port. An upstream agent gives a start pulse together with the total number of bytes. It then offers the bytes on a valid/ready byte stream. The block drives an active-low program strobe, a configuration clock and a serial data line. It watches two status lines from the target: an active-low initialisation line and a completion line.

A load has four phases. First the program strobe is held low until the target acknowledges by pulling its initialisation line low. Then the strobe is released and the block waits for that line to go high again. Next the bytes are shifted out, most significant bit first. Finally the data line is held high and clocking continues until the target raises its completion line. Each waiting phase is bounded by a cycle-count timeout. The outcome is reported as a 2-bit code. The bit rate is set by a half-period divider parameter.

Top module: `cfg_serial_loader`

## Requirements
- R1: A start pulse sampled while idle drives prog_n_o low and busy_o high from the next cycle. prog_n_o stays low until init_n_i is sampled low, and goes high in the following cycle.
- R2: After the program strobe is released, no configuration clock edge occurs and s_ready_o stays low until init_n_i is sampled high.
- R3: Each byte is sent as 8 bits, most significant first. For each bit, cclk_o is low for HALF_DIV cycles with the new bit on dout_o, then high for HALF_DIV cycles with dout_o unchanged. The target samples on the rising edge.
- R4: Before each new byte is accepted, init_n_i low together with done_i low ends the load with result 2'b11. That byte is not accepted.
- R5: After the last byte, dout_o is held high and cclk_o toggles every HALF_DIV cycles until done_i is sampled high. The load then ends with result 2'b00.
- R6: Each wait phase has its own limit of WAIT_CYCLES cycles. An expired wait for init_n_i, in either direction, ends the load with result 2'b01. An expired wait for done_i ends it with result 2'b10.
- R7: A start pulse while busy_o is high is ignored. Neither the running transfer nor its byte count changes.
- R8: s_ready_o is high only while the block waits for the next byte, with bytes remaining and no CRC condition present. cclk_o is low at that time.
- R9: After reset busy_o is 0, prog_n_o is 1 and result_o is 2'b00. result_o keeps its value until the next load ends.
- R10: A byte count of zero skips the data phase and goes straight from the initialisation handshake to the completion wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| byte_count_i | input | CNT_W | Number of bytes in the bitstream, sampled with start_i |
| s_data_i | input | 8 | Upstream byte |
| s_valid_i | input | 1 | Upstream byte valid |
| s_ready_o | output | 1 | Block accepts a byte this cycle |
| prog_n_o | output | 1 | Active-low program strobe to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| dout_o | output | 1 | Serial configuration data to the target |
| init_n_i | input | 1 | Active-low initialisation status from the target |
| done_i | input | 1 | Completion status from the target |
| busy_o | output | 1 | Load in progress |
| result_o | output | 2 | Outcome: 00 ok, 01 init timeout, 10 done timeout, 11 CRC error |

## Verification
Successful loads are run with a continuous stream and with a stream that has gaps. This separates the shift timing from the wait for upstream data. Completion is raised either at once or after several trailing clocks, which tests the final clocking phase. Separate runs use a zero-length load and targets that never acknowledge the strobe, never release initialisation, raise a CRC fault after the second byte, or never complete. Each of these picks out one exit path and its result code. A stray start pulse during a transfer shows whether requests are ignored while busy.

// File: rtl/cfg_sload_pkg.sv
package cfg_sload_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_INITW,
      ST_FETCH,
      ST_SHIFT,
      ST_FLUSH
   } ld_state_e;

   typedef enum logic [1:0] {
      RES_OK      = 2'b00,
      RES_INIT_TO = 2'b01,
      RES_DONE_TO = 2'b10,
      RES_CRC     = 2'b11
   } ld_result_e;

endpackage

// File: rtl/cfg_half_timer.sv
module cfg_half_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("cfg_half_timer: HALF_DIV must be at least 1");
      end
      if (HALF_DIV == 1) begin : g_every
         assign tick = !clr;
      end else begin : g_count
         logic [HW-1:0] cnt_q;
         assign tick = !clr && (cnt_q == HW'(HALF_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt_q <= '0;
            else if (clr || tick) cnt_q <= '0;
            else                 cnt_q <= cnt_q + HW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("cfg_wait_timer: LIMIT must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cnt_q;
   assign expired = (cnt_q == TW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + TW'(1);
   end

   AST_WAIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> (clr || expired)); // R6
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   output logic         next_bit,
   output logic         last
);
   localparam int BW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("cfg_bit_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  sh_q;
   logic [BW-1:0] left_q;

   assign next_bit = sh_q[W-2];
   assign last     = (left_q == BW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= din;
         left_q <= BW'(W);
      end else if (shift) begin
         sh_q   <= {sh_q[W-2:0], 1'b0};
         left_q <= left_q - BW'(1);
      end
   end

   AST_SHIFT_NOT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> (left_q > BW'(1))); // R3
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_sload_pkg::*;
#(
   parameter int HALF_DIV    = 4,
   parameter int WAIT_CYCLES = 1000000,
   parameter int CNT_W       = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] byte_count_i,
   input  logic [7:0]       s_data_i,
   input  logic             s_valid_i,
   output logic             s_ready_o,
   output logic             prog_n_o,
   output logic             cclk_o,
   output logic             dout_o,
   input  logic             init_n_i,
   input  logic             done_i,
   output logic             busy_o,
   output logic [1:0]       result_o
);
   localparam int BYTE_W = 8;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cfg_serial_loader: CNT_W must be at least 1");
      end
   endgenerate

   ld_state_e        st_q, st_d;
   ld_result_e       res_q;
   logic [CNT_W-1:0] left_q;
   logic             cclk_q, dout_q;
   logic             tick, expired, nxt_bit, last_bit;
   logic             crc_hit, have_bytes, take, waiting, phase_clr, shift_en;

   assign crc_hit    = !init_n_i && !done_i;
   assign have_bytes = (left_q != '0);
   assign s_ready_o  = (st_q == ST_FETCH) && have_bytes && !crc_hit;
   assign take       = s_ready_o && s_valid_i;
   assign waiting    = (st_q == ST_PROG) || (st_q == ST_INITW) || (st_q == ST_FLUSH);
   assign phase_clr  = !((st_q == ST_SHIFT) || (st_q == ST_FLUSH));
   assign shift_en   = (st_q == ST_SHIFT) && tick && cclk_q && !last_bit;

   cfg_half_timer #(.HALF_DIV(HALF_DIV)) u_half (
      .clk(clk), .rst_n(rst_n), .clr(phase_clr), .tick(tick));

   cfg_wait_timer #(.LIMIT(WAIT_CYCLES)) u_wait (
      .clk(clk), .rst_n(rst_n), .clr((st_d != st_q) || !waiting), .expired(expired));

   cfg_bit_shifter #(.W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(take), .din(s_data_i), .shift(shift_en),
      .next_bit(nxt_bit), .last(last_bit));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (start_i) st_d = ST_PROG;
         ST_PROG:  if (!init_n_i) st_d = ST_INITW;
                   else if (expired) st_d = ST_IDLE;
         ST_INITW: if (init_n_i) st_d = ST_FETCH;
                   else if (expired) st_d = ST_IDLE;
         ST_FETCH: if (!have_bytes) st_d = ST_FLUSH;
                   else if (crc_hit) st_d = ST_IDLE;
                   else if (s_valid_i) st_d = ST_SHIFT;
         ST_SHIFT: if (tick && cclk_q && last_bit) st_d = ST_FETCH;
         ST_FLUSH: if (done_i || expired) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         res_q  <= RES_OK;
         left_q <= '0;
         cclk_q <= 1'b0;
         dout_q <= 1'b1;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            ST_IDLE:  if (start_i) left_q <= byte_count_i;
            ST_PROG:  if (init_n_i && expired) res_q <= RES_INIT_TO;
            ST_INITW: if (!init_n_i && expired) res_q <= RES_INIT_TO;
            ST_FETCH: begin
               if (!have_bytes) begin
                  cclk_q <= 1'b0;
                  dout_q <= 1'b1;
               end else if (crc_hit) begin
                  res_q <= RES_CRC;
               end else if (s_valid_i) begin
                  left_q <= left_q - CNT_W'(1);
                  cclk_q <= 1'b0;
                  dout_q <= s_data_i[BYTE_W-1];
               end
            end
            ST_SHIFT: if (tick) begin
               if (!cclk_q) cclk_q <= 1'b1;
               else begin
                  cclk_q <= 1'b0;
                  if (!last_bit) dout_q <= nxt_bit;
               end
            end
            ST_FLUSH: begin
               if (done_i) begin
                  res_q  <= RES_OK;
                  cclk_q <= 1'b0;
               end else if (expired) begin
                  res_q  <= RES_DONE_TO;
                  cclk_q <= 1'b0;
               end else if (tick) begin
                  cclk_q <= !cclk_q;
               end
            end
            default: ;
         endcase
      end
   end

   assign prog_n_o = (st_q != ST_PROG);
   assign busy_o   = (st_q != ST_IDLE);
   assign cclk_o   = cclk_q;
   assign dout_o   = dout_q;
   assign result_o = res_q;

   AST_PROG_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> busy_o); // R1
   AST_NO_CLOCK_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_PROG) || (st_q == ST_INITW)) |-> !cclk_o); // R2
   AST_DATA_STABLE_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk_o && $past(cclk_o)) |-> $stable(dout_o)); // R3
   AST_CRC_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_FETCH) && have_bytes && !init_n_i && !done_i)
         |=> (!busy_o && result_o == RES_CRC)); // R4
   AST_FLUSH_DATA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FLUSH) |-> dout_o); // R5
   AST_READY_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (busy_o && !cclk_o)); // R8
   AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> $stable(result_o)); // R9
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
   localparam int DIV   = 2;
   localparam int TO    = 60;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CNT_W-1:0] byte_count_i = '0;
   logic [7:0] s_data_i = '0;
   logic s_valid_i = 1'b0;
   logic init_n_i = 1'b1;
   logic done_i = 1'b0;
   logic s_ready_o, prog_n_o, cclk_o, dout_o, busy_o;
   logic [1:0] result_o;

   always #5 clk = ~clk;

   cfg_serial_loader #(.HALF_DIV(DIV), .WAIT_CYCLES(TO), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
      .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
      .prog_n_o(prog_n_o), .cclk_o(cclk_o), .dout_o(dout_o),
      .init_n_i(init_n_i), .done_i(done_i), .busy_o(busy_o), .result_o(result_o));

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // upstream source
   byte unsigned src_q[$];
   int src_idx = 0;
   bit gap_mode = 0;
   bit take_q = 0;

   // target configuration
   int cfg_init_lo = 3, cfg_init_hi = 4, cfg_done_after = 2, cfg_crc_at = -1, exp_cnt = 0;
   byte unsigned rx_q[$];

   // reference model state
   int mst = 0, m_cnt = 0, m_h = 0, m_bits = 0, m_left = 0, m_res = 0;
   bit m_cclk = 0, m_dout = 1;
   logic [7:0] m_byte = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mst = 0; m_cnt = 0; m_h = 0; m_bits = 0; m_left = 0; m_res = 0;
         m_cclk = 0; m_dout = 1;
      end else begin
         case (mst)
            0: if (start_i) begin mst = 1; m_left = int'(byte_count_i); m_cnt = 0; end
            1: if (!init_n_i) begin mst = 2; m_cnt = 0; end
               else if (m_cnt == TO - 1) begin m_res = 1; mst = 0; end
               else m_cnt++;
            2: if (init_n_i) mst = 3;
               else if (m_cnt == TO - 1) begin m_res = 1; mst = 0; end
               else m_cnt++;
            3: if (m_left == 0) begin mst = 5; m_cnt = 0; m_h = 0; m_cclk = 0; m_dout = 1; end
               else if (!init_n_i && !done_i) begin m_res = 3; mst = 0; end
               else if (s_valid_i) begin
                  m_byte = s_data_i; m_bits = 8; mst = 4; m_h = 0;
                  m_cclk = 0; m_dout = s_data_i[7]; m_left--;
               end
            4: if (m_h == DIV - 1) begin
                  m_h = 0;
                  if (!m_cclk) m_cclk = 1;
                  else if (m_bits > 1) begin
                     m_bits--; m_byte = m_byte << 1; m_dout = m_byte[7]; m_cclk = 0;
                  end else begin mst = 3; m_cclk = 0; end
               end else m_h++;
            5: if (done_i) begin m_res = 0; mst = 0; m_cclk = 0; end
               else if (m_cnt == TO - 1) begin m_res = 2; mst = 0; m_cclk = 0; end
               else begin
                  m_cnt++;
                  if (m_h == DIV - 1) begin m_h = 0; m_cclk = !m_cclk; end else m_h++;
               end
            default: mst = 0;
         endcase
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      bit e_ready;
      cyc++;
      e_ready = (mst == 3) && (m_left != 0) && !(!init_n_i && !done_i);
      chk("R1 prog_n_o", int'(prog_n_o), int'(mst != 1));
      chk("R3 cclk_o", int'(cclk_o), int'(m_cclk));
      chk("R3 dout_o", int'(dout_o), int'(m_dout));
      chk("R8 s_ready_o", int'(s_ready_o), int'(e_ready));
      chk("R7 busy_o", int'(busy_o), int'(mst != 0));
      chk("R9 result_o", int'(result_o), m_res);
      take_q = s_ready_o && s_valid_i;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog R1: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // upstream byte source
   always @(posedge clk) begin
      #2;
      if (take_q) src_idx++;
      s_valid_i = (src_idx < src_q.size()) && !(gap_mode && (cyc % 3 == 0));
      s_data_i  = s_valid_i ? src_q[src_idx] : 8'h00;
   end

   // target device responder
   int ph = 0, tcnt = 0, rxn = 0, bitn = 0, edges_after = 0;
   bit prev_cclk = 0;
   logic [7:0] rsh = 0;
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         init_n_i = 1; done_i = 0; ph = 0;
      end else if (!prog_n_o) begin
         if (ph != 1) begin
            ph = 1; tcnt = 0; done_i = 0; rxn = 0; bitn = 0; edges_after = 0;
            rx_q.delete();
         end else begin
            tcnt++;
            if (cfg_init_lo >= 0 && tcnt >= cfg_init_lo) init_n_i = 0;
         end
      end else if (ph == 1) begin
         ph = 2; tcnt = 0;
      end else if (ph == 2) begin
         tcnt++;
         if (cfg_init_hi >= 0 && tcnt >= cfg_init_hi) begin init_n_i = 1; ph = 3; end
      end else if (ph == 3) begin
         if (cclk_o && !prev_cclk) begin
            if (rxn < exp_cnt) begin
               rsh = {rsh[6:0], dout_o}; bitn++;
               if (bitn == 8) begin
                  rx_q.push_back(rsh); rxn++; bitn = 0;
                  if (rxn == cfg_crc_at) init_n_i = 0;
               end
            end else edges_after++;
         end
         if (rxn == exp_cnt && cfg_done_after >= 0 && edges_after >= cfg_done_after
             && cfg_crc_at < 0) done_i = 1;
      end
      prev_cclk = cclk_o;
   end

   task automatic run_load(input int cnt, input int seed, input bit gaps,
                           input int extra_at, input int exp_res, input string tag,
                           input int exp_rx);
      int k = 0;
      @(posedge clk); #3;
      src_q.delete();
      src_idx = 0;
      for (int i = 0; i < cnt; i++) src_q.push_back(8'((i * 37 + seed) ^ (i << 4)));
      gap_mode = gaps;
      exp_cnt = cnt;
      byte_count_i = CNT_W'(cnt);
      start_i = 1;
      forever begin
         @(posedge clk); #3;
         start_i = (k == extra_at);
         if (k == extra_at) byte_count_i = CNT_W'(1);
         if (!busy_o) break;
         k++;
      end
      start_i = 0;
      chk({tag, " result"}, int'(result_o), exp_res);
      chk({tag, " bytes received"}, rx_q.size(), exp_rx);
      for (int i = 0; i < rx_q.size() && i < src_q.size(); i++)
         chk("R3 byte value", int'(rx_q[i]), int'(src_q[i]));
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk("R9 reset busy", int'(busy_o), 0);
      chk("R9 reset prog_n", int'(prog_n_o), 1);
      chk("R9 reset result", int'(result_o), 0);
      repeat (3) @(posedge clk);
      #3 rst_n = 1;

      // R5: plain success
      run_load(4, 5, 0, -1, 0, "R5 success", 4);
      // R3 gaps in the stream, R5 done raised at once
      cfg_done_after = 0;
      run_load(6, 11, 1, -1, 0, "R3 gapped success", 6);
      // R10 zero bytes
      cfg_done_after = 3;
      run_load(0, 1, 0, -1, 0, "R10 zero count", 0);
      // R7 stray start while busy
      run_load(3, 90, 0, 40, 0, "R7 start ignored", 3);
      // R6 init never acknowledged
      cfg_init_lo = -1;
      run_load(2, 3, 0, -1, 1, "R6 init start timeout", 0);
      // R2 / R6 init never released
      cfg_init_lo = 3; cfg_init_hi = -1;
      run_load(2, 3, 0, -1, 1, "R2 init clear timeout", 0);
      // R4 CRC fault after the second byte
      cfg_init_hi = 4; cfg_crc_at = 2;
      run_load(5, 7, 0, -1, 3, "R4 crc abort", 2);
      // R6 done never rises
      cfg_crc_at = -1; cfg_done_after = -1;
      run_load(3, 21, 0, -1, 2, "R6 done timeout", 3);
      // R9 result held while idle
      repeat (20) @(negedge clk);
      chk("R9 result held", int'(result_o), 2);
      cfg_done_after = 1;
      run_load(2, 44, 0, -1, 0, "R5 recovery", 2);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule